// File: doc/BRIEF.md
# Power-Management Event Hub with SMI Handshake and SCI Routing

The hub gathers eight system and power-management event inputs into sticky status bits and raises two kinds of interrupt from them. The first is the system-management interrupt, issued as a single-cycle message pulse. An end-of-SMI flag gates it: hardware drops the flag whenever it sends a message, and software must set the flag again before another message can go out. The second is the SCI, a level interrupt for the operating system. A routing stage places it on one legacy or APIC interrupt line and applies that line's polarity.

Each input has a fixed class: SCI only, SMI only, or either. For inputs of the last class, a global steering bit chooses the path. When the bit is 1 they raise SCI, and when it is 0 they raise SMI. Software uses a four-word register port to read status, clear it by writing ones, set enables, steer events, re-arm the SMI handshake and pick the SCI line.

Top module: `pm_evt_hub`

Input map (bit: class): 0 power button (either), 1 PCIe PME (either; its enable gates only SCI), 2 button override (SCI only), 3 software 64 ms timer (SMI only), 4 APM port write (SMI only), 5 LAN wake (either, qualified), 6 RTC alarm (either), 7 processor TCO SCI message (SCI only).

Register map (`addr`): 0 status, write-one-to-clear, bits 7:0. 1 enable, bits 7:0. 2 control: bit 0 steering (1 = SCI), bit 1 end-of-SMI (writing 1 sets it, writing 0 has no effect). 3 route: bit 8 APIC mode, bits 4:0 line number.

## Requirements
- R1: A status bit sets one cycle after its input goes from 0 to 1. It then stays set, even while the input remains high, until software clears it.
- R2: Writing 1 to a status bit at address 0 clears it. If the clear and a new rising edge arrive in the same cycle, the bit stays set.
- R3: Inputs 2 and 7 raise only SCI and inputs 3 and 4 raise only SMI. Inputs 0, 1, 5 and 6 raise SCI when the steering bit is 1 and SMI when it is 0. An input contributes only while its enable bit is 1, except as R8 states.
- R4: An SMI fires when the end-of-SMI bit is 1 and an enabled SMI-routed status is set. `smi_msg` is then high for exactly one cycle, and end-of-SMI reads 0 from that cycle on.
- R5: While end-of-SMI is 0, `smi_msg` stays low, however many events are pending.
- R6: If software writes 1 to end-of-SMI while an SMI-routed status is still pending, a new pulse appears two cycles after the write. If nothing is pending, end-of-SMI stays 1.
- R7: `sci_level` is high while any enabled SCI-routed status is set. It falls one cycle after the last such status is cleared.
- R8: The enable of input 1 gates only its SCI path. When the steering bit is 0, its status raises SMI whatever its enable bit holds.
- R9: The status of input 5 can set only while the steering bit is 0 and enable bit 5 is 1. Edges at any other time are discarded.
- R10: In legacy mode the route accepts lines 9, 10 and 11. In APIC mode it also accepts lines 20 to 23. A write of any other pair leaves the previous route unchanged. The route resets to legacy line 9.
- R11: `sci_pin` is active high on unshared lines and active low on shared lines. Lines 20 to 23 are shared by default.
- R12: After reset, status and enables are 0, steering is 0, end-of-SMI is 1, and both interrupts are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 8 | Event inputs, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from addr |
| smi_msg | output | 1 | One-cycle SMI message pulse |
| sci_level | output | 1 | SCI request before polarity |
| sci_pin | output | 1 | SCI on the selected line, with that line's polarity |
| sci_line | output | 5 | Selected SCI line number |

## Verification
A rising input appears in status one clock after it is sampled. The interrupts follow one clock after that, so `smi_msg` and `sci_level` respond two edges after the input. A register write takes effect at the edge that samples it. An interrupt that depends on that write moves at the following edge, and the route and pin respond at once. The bench drives inputs at falling edges and reads results at the falling edge after the edge where the result is due. It also checks the cycle before and the cycle after each pulse, so an early or late pulse fails.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;

    localparam int LINE_W = 5;

    typedef enum logic [1:0] {
        REG_STS   = 2'd0,
        REG_EN    = 2'd1,
        REG_CTL   = 2'd2,
        REG_ROUTE = 2'd3
    } reg_sel_e;

    // legal SCI destination for the given routing mode
    function automatic logic line_ok(input logic apic, input logic [LINE_W-1:0] line);
        logic legacy_ok;
        logic apic_ok;
        legacy_ok = (line == 5'd9) || (line == 5'd10) || (line == 5'd11);
        apic_ok   = (line >= 5'd20) && (line <= 5'd23);
        return legacy_ok || (apic && apic_ok);
    endfunction

endpackage

// File: rtl/pm_evt_status.sv
module pm_evt_status #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    input  logic [N-1:0] qual_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] sts_o
);

    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] sts;
    } st_t;

    st_t st_d, st_q;
    logic [N-1:0] set_edge;

    always_comb begin
        st_d = st_q;
        st_d.prev = src_i;
        for (int i = 0; i < N; i++) begin
            set_edge[i]   = src_i[i] & ~st_q.prev[i] & qual_i[i];
            st_d.sts[i]   = set_edge[i] | (st_q.sts[i] & ~clr_i[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts_o = st_q.sts;

    // R1
    sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.sts & $past(st_q.sts & ~clr_i)) == $past(st_q.sts & ~clr_i)));

    // R2
    edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.sts & $past(src_i & ~st_q.prev & qual_i)) == $past(src_i & ~st_q.prev & qual_i)));

    // R9
    qual_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.sts & ~$past(st_q.sts) & ~$past(qual_i)) == '0));

endmodule

// File: rtl/pm_evt_smi_gate.sv
module pm_evt_smi_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic pend_i,
    input  logic arm_i,
    output logic msg_o,
    output logic eos_o
);

    typedef struct packed {
        logic eos;
        logic msg;
    } gate_t;

    gate_t g_d, g_q;
    logic  fire;

    always_comb begin
        g_d   = g_q;
        fire  = g_q.eos & pend_i;
        g_d.msg = fire;
        if (fire)       g_d.eos = 1'b0;
        else if (arm_i) g_d.eos = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '{eos: 1'b1, msg: 1'b0};
        else        g_q <= g_d;
    end

    assign msg_o = g_q.msg;
    assign eos_o = g_q.eos;

    // R4
    smi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_o |=> !msg_o);

    // R4
    smi_eos_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_o |-> !eos_o);

    // R5
    smi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eos_o |=> !msg_o);

    // R6
    smi_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eos_o && pend_i) |=> msg_o);

endmodule

// File: rtl/pm_evt_sci_route.sv
module pm_evt_sci_route #(
    parameter logic [31:0]                      SHARED_LINES = 32'h00F0_0000,
    parameter logic [pm_evt_pkg::LINE_W-1:0]    RESET_LINE   = 5'd9
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_i,
    input  logic                           apic_i,
    input  logic [pm_evt_pkg::LINE_W-1:0]  line_i,
    input  logic                           sci_i,
    output logic                           apic_o,
    output logic [pm_evt_pkg::LINE_W-1:0]  line_o,
    output logic                           level_o,
    output logic                           pin_o
);
    import pm_evt_pkg::*;

    typedef struct packed {
        logic              apic;
        logic [LINE_W-1:0] line;
        logic              lvl;
    } route_t;

    route_t rt_d, rt_q;

    always_comb begin
        rt_d     = rt_q;
        rt_d.lvl = sci_i;
        if (wr_i && line_ok(apic_i, line_i)) begin
            rt_d.apic = apic_i;
            rt_d.line = line_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rt_q <= '{apic: 1'b0, line: RESET_LINE, lvl: 1'b0};
        else        rt_q <= rt_d;
    end

    assign apic_o  = rt_q.apic;
    assign line_o  = rt_q.line;
    assign level_o = rt_q.lvl;
    assign pin_o   = SHARED_LINES[rt_q.line] ? ~rt_q.lvl : rt_q.lvl;

    // R10
    route_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_ok(rt_q.apic, rt_q.line));

    // R10
    route_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !line_ok(apic_i, line_i)) |=> ($stable(rt_q.line) && $stable(rt_q.apic)));

endmodule

// File: rtl/pm_evt_hub.sv
module pm_evt_hub #(
    parameter int                 N_SRC        = 8,
    parameter int                 DATA_W       = 16,
    parameter logic [N_SRC-1:0]   SCI_CAP      = 8'hE7,
    parameter logic [N_SRC-1:0]   SMI_CAP      = 8'h7B,
    parameter logic [N_SRC-1:0]   SMI_NOGATE   = 8'h02,
    parameter logic [N_SRC-1:0]   WAKE_QUAL    = 8'h20,
    parameter logic [31:0]        SHARED_LINES = 32'h00F0_0000,
    parameter logic [4:0]         RESET_LINE   = 5'd9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_i,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              smi_msg,
    output logic              sci_level,
    output logic              sci_pin,
    output logic [4:0]        sci_line
);
    import pm_evt_pkg::*;

    localparam int CTL_STEER = 0;
    localparam int CTL_EOS   = 1;
    localparam int RT_APIC   = 8;

    typedef struct packed {
        logic [N_SRC-1:0] en;
        logic             steer;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [N_SRC-1:0] sts, clr, qual, sci_route, smi_route;
    logic             sci_pend, smi_pend, arm, route_wr, eos, route_apic;
    logic             unused_wdata;
    reg_sel_e         sel;

    assign sel          = reg_sel_e'(addr);
    assign unused_wdata = ^wdata;

    always_comb begin
        cfg_d    = cfg_q;
        clr      = '0;
        arm      = 1'b0;
        route_wr = 1'b0;
        if (wr_en) begin
            case (sel)
                REG_STS:   clr = wdata[N_SRC-1:0];
                REG_EN:    cfg_d.en = wdata[N_SRC-1:0];
                REG_CTL: begin
                    cfg_d.steer = wdata[CTL_STEER];
                    arm         = wdata[CTL_EOS];
                end
                default:   route_wr = 1'b1;
            endcase
        end
        qual      = ~WAKE_QUAL | (cfg_q.en & {N_SRC{~cfg_q.steer}});
        sci_route = SCI_CAP & (~SMI_CAP | {N_SRC{cfg_q.steer}});
        smi_route = SMI_CAP & (~SCI_CAP | {N_SRC{~cfg_q.steer}});
        sci_pend  = |(sts & cfg_q.en & sci_route);
        smi_pend  = |(sts & (cfg_q.en | SMI_NOGATE) & smi_route);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    pm_evt_status #(.N(N_SRC)) status_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_i),
        .qual_i (qual),
        .clr_i  (clr),
        .sts_o  (sts)
    );

    pm_evt_smi_gate smi_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (smi_pend),
        .arm_i  (arm),
        .msg_o  (smi_msg),
        .eos_o  (eos)
    );

    pm_evt_sci_route #(
        .SHARED_LINES (SHARED_LINES),
        .RESET_LINE   (RESET_LINE)
    ) route_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (route_wr),
        .apic_i  (wdata[RT_APIC]),
        .line_i  (wdata[LINE_W-1:0]),
        .sci_i   (sci_pend),
        .apic_o  (route_apic),
        .line_o  (sci_line),
        .level_o (sci_level),
        .pin_o   (sci_pin)
    );

    always_comb begin
        rdata = '0;
        case (sel)
            REG_STS:   rdata[N_SRC-1:0] = sts;
            REG_EN:    rdata[N_SRC-1:0] = cfg_q.en;
            REG_CTL: begin
                rdata[CTL_STEER] = cfg_q.steer;
                rdata[CTL_EOS]   = eos;
            end
            default: begin
                rdata[RT_APIC]       = route_apic;
                rdata[LINE_W-1:0]    = sci_line;
            end
        endcase
    end

endmodule

// File: tb/pm_evt_hub_tb_top.sv
module pm_evt_hub_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  src = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        smi_msg, sci_level, sci_pin;
    logic [4:0]  sci_line;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    pm_evt_hub dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .smi_msg(smi_msg), .sci_level(sci_level),
        .sci_pin(sci_pin), .sci_line(sci_line)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step(); @(negedge clk); endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic pulse(input int b);
        src[b] = 1'b1;
        step();
        src[b] = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(2'd0, v); chk("R12 status", v, 0);
        rd(2'd1, v); chk("R12 enable", v, 0);
        rd(2'd2, v); chk("R12 control", v, 16'h2);
        rd(2'd3, v); chk("R12/R10 route", v, 16'h009);
        chk("R12 smi", smi_msg, 0);
        chk("R12 sci", sci_level, 0);
        chk("R12/R11 pin idle", sci_pin, 0);
    endtask

    task automatic t_smi();
        logic [15:0] v;
        wr(2'd1, 16'hFF);
        pulse(4);
        rd(2'd0, v); chk("R1 status set", v, 16'h10);
        chk("R4 no early pulse", smi_msg, 0);
        step(); chk("R4 pulse", smi_msg, 1);
        rd(2'd2, v); chk("R4 eos dropped", v, 16'h0);
        step(); chk("R4 pulse width", smi_msg, 0);
        pulse(3);
        for (int i = 0; i < 4; i++) begin
            step(); chk("R5 held off", smi_msg, 0);
        end
        wr(2'd2, 16'h2);
        chk("R6 not yet", smi_msg, 0);
        step(); chk("R6 re-fire", smi_msg, 1);
        wr(2'd0, 16'h18);
        wr(2'd2, 16'h2);
        step(); step();
        chk("R6 idle re-arm", smi_msg, 0);
        rd(2'd2, v); chk("R6 eos kept", v, 16'h2);
        rd(2'd0, v); chk("R2 cleared", v, 16'h0);
    endtask

    task automatic t_class();
        wr(2'd2, 16'h3);
        pulse(0); step();
        chk("R3 either->sci", sci_level, 1);
        chk("R3 either not smi", smi_msg, 0);
        wr(2'd0, 16'h01); step();
        chk("R3 sci drop", sci_level, 0);
        pulse(3); step();
        chk("R3 smi-only with steer=1", smi_msg, 1);
        chk("R3 smi-only no sci", sci_level, 0);
        wr(2'd0, 16'h08);
        wr(2'd2, 16'h2);
        pulse(0); step();
        chk("R3 either->smi", smi_msg, 1);
        chk("R3 either no sci", sci_level, 0);
        wr(2'd0, 16'h01);
        wr(2'd2, 16'h2);
    endtask

    task automatic t_sci();
        wr(2'd2, 16'h3);
        pulse(2); pulse(7); step();
        chk("R7 sci on", sci_level, 1);
        wr(2'd0, 16'h04); step();
        chk("R7 one left", sci_level, 1);
        wr(2'd0, 16'h80); step();
        chk("R7 all cleared", sci_level, 0);
        chk("R3 sci-only no smi", smi_msg, 0);
    endtask

    task automatic t_pcie();
        logic [15:0] v;
        wr(2'd1, 16'hFD);
        pulse(1); step(); step();
        chk("R8 sci gated", sci_level, 0);
        rd(2'd0, v); chk("R8 status", v, 16'h02);
        wr(2'd2, 16'h2);
        step(); chk("R8 smi ungated", smi_msg, 1);
        wr(2'd1, 16'hFF);
        wr(2'd2, 16'h3);
        step();
        chk("R8 sci enabled", sci_level, 1);
        chk("R8 no smi at steer=1", smi_msg, 0);
        wr(2'd0, 16'h02); step();
        chk("R7 sci off", sci_level, 0);
    endtask

    task automatic t_wake();
        logic [15:0] v;
        pulse(5); rd(2'd0, v); chk("R9 steer=1 blocks", v, 0);
        wr(2'd2, 16'h2);
        wr(2'd1, 16'hDF);
        pulse(5); rd(2'd0, v); chk("R9 enable=0 blocks", v, 0);
        wr(2'd1, 16'hFF);
        pulse(5); rd(2'd0, v); chk("R9 qualified set", v, 16'h20);
        step(); chk("R9 smi", smi_msg, 1);
        wr(2'd0, 16'h20);
        wr(2'd2, 16'h2);
    endtask

    task automatic t_sticky();
        logic [15:0] v;
        pulse(6);
        rd(2'd0, v); chk("R1 set", v, 16'h40);
        step(); step(); step();
        rd(2'd0, v); chk("R1 held", v, 16'h40);
        src[6] = 1'b1;
        wr(2'd0, 16'h40);
        rd(2'd0, v); chk("R2 edge beats clear", v, 16'h40);
        wr(2'd0, 16'h40);
        rd(2'd0, v); chk("R2 clear", v, 16'h0);
        step();
        rd(2'd0, v); chk("R1 level no reset", v, 16'h0);
        src[6] = 1'b0;
        wr(2'd2, 16'h2);
    endtask

    task automatic t_route();
        logic [15:0] v;
        wr(2'd3, 16'h014);
        chk("R10 legacy 20 refused", sci_line, 9);
        wr(2'd3, 16'h114);
        chk("R10 apic 20", sci_line, 20);
        rd(2'd3, v); chk("R10 route read", v, 16'h114);
        chk("R11 shared idle high", sci_pin, 1);
        wr(2'd3, 16'h10F);
        chk("R10 apic 15 refused", sci_line, 20);
        wr(2'd2, 16'h3);
        pulse(2); step();
        chk("R11 shared active low", sci_pin, 0);
        wr(2'd3, 16'h00B);
        chk("R10 legacy 11", sci_line, 11);
        chk("R11 unshared active high", sci_pin, 1);
        wr(2'd3, 16'h015);
        chk("R10 legacy 21 refused", sci_line, 11);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_smi();
        t_class();
        t_sci();
        t_pcie();
        t_wake();
        t_sticky();
        t_route();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule